// File: doc/BRIEF.md
# Enhanced Parallel Port Bus Cycle Sequencer

This block converts host I/O reads and writes aimed at port offsets 3 through 7 into handshaked strobe cycles on a parallel peripheral port. It works only while the port mode code equals binary 100. A qualifying host cycle pulls the host ready line low at once, with no clock in the path. The sequencer waits until the peripheral's BUSY line has stayed low for a programmable number of clock cycles. It then marks the transfer direction, drives write data onto the port, and asserts one of two strobes. Offset 3 uses the address strobe. Offsets 4 to 7 use the data strobe.

When BUSY has then stayed high for the same qualification time, the active strobe is withdrawn and ready returns high. Read data from the port is captured on that same edge. If BUSY never reaches the level it is waited for, a timeout counter ends the cycle, releases ready and raises a timeout flag. The host read and write strobes and BUSY pass through synchronisers. A counter measures BUSY-low time continuously, so a qualification that was already met before the cycle began adds no delay.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset, host_rdy is 1, addr_strb_n, data_strb_n and pstrobe_n are 1, pdir is 0, and pd_out, rdata and timeout are 0.
- R2: A cycle starts only when mode_sel equals 3'b100 and host_addr is 3 to 7. Any other mode or offset leaves host_rdy, pstrobe_n, addr_strb_n and data_strb_n at 1.
- R3: While a qualifying host strobe is held, host_rdy is 0 (combinationally, before any clock edge) until the cycle completes or times out.
- R4: pstrobe_n and pd_out change only after the synchronised BUSY has been low for QUAL_CYC cycles. When that time has already passed, the port strobe falls on the 5th rising clock edge after the host strobe falls. When BUSY falls together with the host strobe, it falls no earlier than the 7th edge (QUAL_CYC=3).
- R5: Offset 3 asserts addr_strb_n low. Offsets 4 to 7 assert data_strb_n low. The two are never low together.
- R6: From the start of the handshake until the host strobe is released, pstrobe_n is 0 for writes, and pdir is 1 for reads and 0 for writes.
- R7: Once BUSY has been high for QUAL_CYC cycles, the active strobe returns to 1 and host_rdy returns to 1 on the same clock edge.
- R8: On a write, pd_out carries host_wdata while the port strobe is low. On a read, rdata holds the value of pd_in sampled on the edge at which the strobe is released.
- R9: If BUSY does not reach the awaited level within TMO_CYC cycles, the strobe is released (or never asserted), host_rdy returns to 1 and timeout is 1. The flag clears when the next cycle is accepted.
- R10: After a cycle ends, no new cycle starts until both host strobes have been seen released. A strobe held past completion produces no second handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Port mode code; 3'b100 enables the block |
| host_addr | input | 3 | Host port offset |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wdata | input | DW | Host write data |
| busy | input | 1 | Peripheral BUSY handshake |
| pd_in | input | DW | Data read from the port |
| host_rdy | output | 1 | Host ready; low stretches the host cycle |
| pstrobe_n | output | 1 | Write indicator, low for writes |
| pdir | output | 1 | Port direction, 1 = input from peripheral |
| addr_strb_n | output | 1 | Address strobe, active low |
| data_strb_n | output | 1 | Data strobe, active low |
| pd_out | output | DW | Data driven to the port |
| rdata | output | DW | Captured read data |
| timeout | output | 1 | Set when a cycle was ended by timeout |

## Verification
The assertions assume that the host keeps its strobe, address and write data steady from the start of a cycle until ready returns high. They also assume that the host never asserts read and write together and that mode_sel does not change during a cycle. The bench drives every host signal on the falling clock edge and holds it until it sees ready high. It leaves at least eight idle cycles between host cycles. The peripheral model moves BUSY only after it has seen a strobe change.

// File: rtl/epp_pkg.sv
package epp_pkg;

  localparam logic [2:0] MODE_EPP = 3'b100;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WLOW,
    S_STRB,
    S_ACT,
    S_DONE
  } epp_st_e;

  function automatic logic in_epp_window(input logic [2:0] a);
    return a >= 3'd3;
  endfunction

  function automatic logic uses_addr_strobe(input logic [2:0] a);
    return a == 3'd3;
  endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_busy_qual.sv
module epp_busy_qual #(
  parameter int QUAL_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_s,
  output logic low_ok,
  output logic high_ok
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_CYC);

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (busy_s) begin
      lo_cnt <= '0;
      hi_cnt <= (hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      lo_cnt <= (lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1;
    end
  end

  assign low_ok  = (lo_cnt == CMAX);
  assign high_ok = (hi_cnt == CMAX);

  // R4
  qual_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_ok && high_ok));

  // R4
  qual_low_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_ok) |-> $past(!busy_s));
endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_pkg::*;
#(
  parameter int DW = 8,
  parameter int TMO_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ok,
  input  logic          wr_act,
  input  logic          rd_act,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pd_in,
  input  logic          low_ok,
  input  logic          high_ok,
  output logic          pstrobe_n,
  output logic          pdir,
  output logic          addr_strb_n,
  output logic          data_strb_n,
  output logic [DW-1:0] pd_out,
  output logic [DW-1:0] rdata,
  output logic          timeout,
  output logic          done,
  output logic          accept,
  output logic          hs_done
);
  localparam int TCW = $clog2(TMO_CYC + 1);
  localparam logic [TCW-1:0] TLAST = TCW'(TMO_CYC - 1);

  epp_st_e        st;
  logic           sel_a, is_wr, hs_on;
  logic [DW-1:0]  wr_hold;
  logic [TCW-1:0] tmo_cnt;
  logic           tmo_hit;

  assign accept  = (st == S_IDLE) && mode_ok && in_epp_window(addr) && (wr_act || rd_act);
  assign hs_done = (st == S_ACT) && high_ok;
  assign tmo_hit = (tmo_cnt == TLAST);
  assign done    = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sel_a   <= 1'b0;
      is_wr   <= 1'b0;
      hs_on   <= 1'b0;
      wr_hold <= '0;
      pd_out  <= '0;
      rdata   <= '0;
      timeout <= 1'b0;
      tmo_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_WLOW;
          sel_a   <= uses_addr_strobe(addr);
          is_wr   <= wr_act;
          if (wr_act) wr_hold <= wdata;
          timeout <= 1'b0;
          tmo_cnt <= '0;
        end
        S_WLOW: if (low_ok) begin
          st      <= S_STRB;
          hs_on   <= 1'b1;
          tmo_cnt <= '0;
          if (is_wr) pd_out <= wr_hold;
        end else if (tmo_hit) begin
          st      <= S_DONE;
          timeout <= 1'b1;
        end else begin
          tmo_cnt <= tmo_cnt + 1'b1;
        end
        S_STRB: st <= S_ACT;
        S_ACT: if (high_ok) begin
          st <= S_DONE;
          if (!is_wr) rdata <= pd_in;
        end else if (tmo_hit) begin
          st      <= S_DONE;
          timeout <= 1'b1;
        end else begin
          tmo_cnt <= tmo_cnt + 1'b1;
        end
        S_DONE: if (!wr_act && !rd_act) begin
          st    <= S_IDLE;
          hs_on <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pstrobe_n   = !(hs_on && is_wr);
  assign pdir        = hs_on && !is_wr;
  assign addr_strb_n = !((st == S_ACT) && sel_a);
  assign data_strb_n = !((st == S_ACT) && !sel_a);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!addr_strb_n, !data_strb_n}));

  // R6
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pstrobe_n |-> !pdir);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_done |=> (addr_strb_n && data_strb_n && done));

  // R9
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_cnt <= TLAST);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (wr_act || rd_act)) |=> done);
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int DW = 8,
  parameter int QUAL_CYC = 3,
  parameter int TMO_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic [2:0]    host_addr,
  input  logic          host_wr_n,
  input  logic          host_rd_n,
  input  logic [DW-1:0] host_wdata,
  input  logic          busy,
  input  logic [DW-1:0] pd_in,
  output logic          host_rdy,
  output logic          pstrobe_n,
  output logic          pdir,
  output logic          addr_strb_n,
  output logic          data_strb_n,
  output logic [DW-1:0] pd_out,
  output logic [DW-1:0] rdata,
  output logic          timeout
);
  logic [2:0] sync_in, sync_out;
  logic       wr_act, rd_act, busy_s;
  logic       low_ok, high_ok;
  logic       mode_ok, req_raw;
  logic       done, accept, hs_done;

  assign sync_in = {busy, host_rd_n, host_wr_n};

  epp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_out)
  );

  assign wr_act = !sync_out[0];
  assign rd_act = !sync_out[1];
  assign busy_s = sync_out[2];

  epp_busy_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .busy_s(busy_s),
    .low_ok(low_ok), .high_ok(high_ok)
  );

  assign mode_ok = (mode_sel == MODE_EPP);
  assign req_raw = mode_ok && in_epp_window(host_addr) && (!host_wr_n || !host_rd_n);
  assign host_rdy = !(req_raw && !done);

  epp_seq #(.DW(DW), .TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_ok(mode_ok),
    .wr_act(wr_act), .rd_act(rd_act), .addr(host_addr),
    .wdata(host_wdata), .pd_in(pd_in),
    .low_ok(low_ok), .high_ok(high_ok),
    .pstrobe_n(pstrobe_n), .pdir(pdir),
    .addr_strb_n(addr_strb_n), .data_strb_n(data_strb_n),
    .pd_out(pd_out), .rdata(rdata), .timeout(timeout),
    .done(done), .accept(accept), .hs_done(hs_done)
  );

  // R3
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strb_n || !data_strb_n) |-> !host_rdy);

  // R2
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> mode_ok);
endmodule

// File: tb/epp_cycle_ctrl_test.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_test;
  localparam int DW = 8;
  localparam int TMO = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode_sel = 3'b100;
  logic [2:0]    host_addr = 3'd0;
  logic          host_wr_n = 1'b1;
  logic          host_rd_n = 1'b1;
  logic [DW-1:0] host_wdata = '0;
  logic          busy = 1'b0;
  logic [DW-1:0] pd_in = '0;
  logic          host_rdy, pstrobe_n, pdir, addr_strb_n, data_strb_n, timeout;
  logic [DW-1:0] pd_out, rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  epp_cycle_ctrl #(.DW(DW), .QUAL_CYC(3), .TMO_CYC(TMO), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_addr(host_addr),
    .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .host_wdata(host_wdata),
    .busy(busy), .pd_in(pd_in), .host_rdy(host_rdy), .pstrobe_n(pstrobe_n),
    .pdir(pdir), .addr_strb_n(addr_strb_n), .data_strb_n(data_strb_n),
    .pd_out(pd_out), .rdata(rdata), .timeout(timeout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_gap();
    host_wr_n = 1'b1;
    host_rd_n = 1'b1;
    busy = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // {addr[3], write[1], wdata[8], pdin[8]}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {3'd3, 1'b1, 8'hA5, 8'h00},
    {3'd4, 1'b1, 8'h3C, 8'h00},
    {3'd7, 1'b1, 8'hFF, 8'h00},
    {3'd3, 1'b0, 8'h00, 8'h5A},
    {3'd5, 1'b0, 8'h00, 8'hC3},
    {3'd6, 1'b0, 8'h00, 8'h81}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(host_rdy == 1'b1, "R1 host_rdy", host_rdy, 1);
    chk(addr_strb_n && data_strb_n, "R1 strobes", {addr_strb_n, data_strb_n}, 3);
    chk(pstrobe_n == 1'b1 && pdir == 1'b0, "R1 pstrobe/pdir", {pstrobe_n, pdir}, 2);
    chk(pd_out == '0 && rdata == '0, "R1 data regs", {pd_out, rdata}, 0);
    chk(timeout == 1'b0, "R1 timeout", timeout, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] a;
      logic       w;
      logic [7:0] wd, pdi;
      int         n;
      {a, w, wd, pdi} = VEC[v];
      host_addr = a;
      host_wdata = wd;
      pd_in = pdi;
      if (w) host_wr_n = 1'b0; else host_rd_n = 1'b0;
      #1;
      chk(host_rdy == 1'b0, "R3 ready low at once", host_rdy, 0);
      n = 0;
      while (addr_strb_n && data_strb_n && n < 60) begin
        @(posedge clk); #1; n++;
      end
      chk(n == 5, "R4 no added delay", n, 5);
      if (a == 3'd3)
        chk(!addr_strb_n && data_strb_n, "R5 address strobe", {addr_strb_n, data_strb_n}, 1);
      else
        chk(addr_strb_n && !data_strb_n, "R5 data strobe", {addr_strb_n, data_strb_n}, 2);
      chk(pstrobe_n == !w && pdir == !w, "R6 direction", {pstrobe_n, pdir}, {!w, !w});
      if (w) chk(pd_out == wd, "R8 write data", pd_out, wd);
      chk(host_rdy == 1'b0, "R3 ready held", host_rdy, 0);
      @(negedge clk); @(negedge clk);
      busy = 1'b1;
      n = 0;
      while (!host_rdy && n < 60) begin
        @(posedge clk); #1; n++;
      end
      chk(host_rdy == 1'b1, "R7 ready released", host_rdy, 1);
      chk(addr_strb_n && data_strb_n, "R7 strobe released", {addr_strb_n, data_strb_n}, 3);
      chk(timeout == 1'b0, "R9 no timeout", timeout, 0);
      if (!w) chk(rdata == pdi, "R8 read capture", rdata, pdi);
      @(negedge clk);
      idle_gap();
      chk(pstrobe_n == 1'b1 && pdir == 1'b0, "R6 idle after release", {pstrobe_n, pdir}, 2);
    end

    // R4 BUSY falls with host strobe: qualification delays the strobe
    begin
      int n;
      busy = 1'b1;
      repeat (8) @(negedge clk);
      host_addr = 3'd4;
      host_wdata = 8'h77;
      host_wr_n = 1'b0;
      busy = 1'b0;
      n = 0;
      while (addr_strb_n && data_strb_n && n < 60) begin
        @(posedge clk); #1; n++;
        if (data_strb_n && n < 6 && pd_out == 8'h77)
          chk(1'b0, "R4 pd_out early", pd_out, 8'h81);
      end
      chk(n >= 7, "R4 qualified delay", n, 7);
      busy = 1'b1;
      while (!host_rdy && n < 120) begin
        @(posedge clk); #1; n++;
      end
      chk(host_rdy == 1'b1, "R7 slow cycle done", host_rdy, 1);
      // R10 hold the write strobe long after completion
      repeat (20) begin
        @(negedge clk);
        if (!data_strb_n || !host_rdy)
          chk(1'b0, "R10 no second cycle", {data_strb_n, host_rdy}, 3);
      end
      chk(data_strb_n && host_rdy, "R10 still idle", {data_strb_n, host_rdy}, 3);
      idle_gap();
    end

    // R2 wrong mode and low offsets ignored
    begin
      logic seen;
      seen = 1'b0;
      mode_sel = 3'b011;
      host_addr = 3'd4;
      host_wr_n = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (!host_rdy || !data_strb_n || !addr_strb_n || !pstrobe_n) seen = 1'b1;
      end
      chk(!seen, "R2 mode gate", seen, 0);
      idle_gap();
      mode_sel = 3'b100;
      seen = 1'b0;
      host_addr = 3'd2;
      host_rd_n = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (!host_rdy || !data_strb_n || !addr_strb_n || pdir) seen = 1'b1;
      end
      chk(!seen, "R2 offset gate", seen, 0);
      idle_gap();
    end

    // R9 timeout while waiting for BUSY low
    begin
      logic seen;
      int n;
      seen = 1'b0;
      busy = 1'b1;
      repeat (8) @(negedge clk);
      host_addr = 3'd5;
      host_wr_n = 1'b0;
      n = 0;
      #1;
      while (!host_rdy && n < 200) begin
        @(posedge clk); #1; n++;
        if (!data_strb_n || !addr_strb_n) seen = 1'b1;
      end
      chk(host_rdy == 1'b1 && n < 200, "R9 ready after timeout", host_rdy, 1);
      chk(timeout == 1'b1, "R9 timeout flag", timeout, 1);
      chk(!seen, "R9 no strobe on timeout", seen, 0);
      idle_gap();
    end

    // R9 timeout while waiting for BUSY high
    begin
      int n;
      host_addr = 3'd3;
      pd_in = 8'h11;
      host_rd_n = 1'b0;
      n = 0;
      while (addr_strb_n && n < 60) begin
        @(posedge clk); #1; n++;
      end
      chk(timeout == 1'b0, "R9 flag cleared on accept", timeout, 0);
      n = 0;
      while (!host_rdy && n < 200) begin
        @(posedge clk); #1; n++;
      end
      chk(host_rdy && addr_strb_n, "R9 strobe released", {host_rdy, addr_strb_n}, 3);
      chk(timeout == 1'b1, "R9 timeout in handshake", timeout, 1);
      chk(rdata == 8'h81, "R9 rdata untouched", rdata, 8'h81);
      idle_gap();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule